// File: doc/BRIEF.md
# Serial Receive Channel with Tagged Byte Queue

This block is the receive half of one asynchronous serial channel. It samples the incoming line at sixteen times the bit rate, rebuilds each character from a start bit, five to eight data bits sent least significant bit first, an optional parity bit and one or two stop bits, and writes the character into a 512-entry queue. Each queue word holds the character together with four status flags: parity error, framing error, overrun and line break. The host sees the number of stored words at any time and removes one tagged word per pop request. A receive-ready output rises when the stored count reaches a selectable threshold. A flush input empties the queue, and nothing is stored unless the receive enable is set.

The deserialiser is a state machine with seven states. IDLE waits for a low sample while receive is enabled and moves to START. START checks the line again at the middle of the start bit; a high sample is a false start and returns to IDLE, a low one moves to DATA. DATA takes one sample per bit period until the configured number of bits has been taken, then moves to PARITY when parity is enabled and to STOP1 otherwise. PARITY takes the parity sample and moves to STOP1. STOP1 moves to HOLD when the stop bit is low (break or framing error), to STOP2 when two stop bits are configured, and to IDLE otherwise. STOP2 moves to IDLE on a high sample and to HOLD on a low one. HOLD waits for the line to return high and then moves to IDLE.

Top module: `serial_rx_tagfifo`

## Requirements
- R1: After reset the occupancy count is 0, the pop data word is 0 and receive-ready is low.
- R2: The data-length field selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3; bits arrive least significant first and are stored right-aligned in bits 7:0 of the word, with the unused high data bits zero.
- R3: One bit lasts 16 × (divisor field + 1) clock cycles, so a divisor field of 0 gives 16 cycles per bit.
- R4: With parity enabled the parity bit follows the data; even-select set means even parity and clear means odd, and with stick set the expected bit is constant (0 when even-select is set, 1 when clear). A mismatch sets bit 8 of the stored word.
- R5: A low first stop bit, or a low second stop bit when two stop bits are selected, sets bit 10 (framing error) of the stored word; afterwards the receiver waits for the line to go high before looking for a new start bit.
- R6: A line held low from the start bit through the first stop bit is stored as one word with data 0x00 and only bit 11 (break) set, and one more character is received normally once the line has returned high.
- R7: A character that completes while the queue holds 512 words is discarded, and the next character that is stored has bit 9 (overrun) set.
- R8: A pop returns the oldest word at the clock edge that samples the request and lowers the count by one; a pop on an empty queue returns 0 and leaves the count unchanged.
- R9: Receive-ready follows the two-bit threshold field: code 0 keeps it low, and codes 1, 2 and 3 raise it while the count is at least 1, 256 and 448.
- R10: While flush is high the count reads 0, completed characters are not kept and any pending overrun mark is cleared.
- R11: Characters that complete while receive enable is low are not stored.
- R12: The occupancy output is 16 bits wide, never exceeds 512 and changes by at most one per clock outside a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | Allows received characters to be stored |
| flush_rx | input | 1 | Empties the queue while high |
| baud_div_m1 | input | 16 | Bit-rate divisor minus one |
| data_len_sel | input | 2 | Data length: 0=5, 1=6, 2=7, 3=8 bits |
| two_stop | input | 1 | Two stop bits when set |
| par_enable | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity when set, odd when clear |
| par_stick | input | 1 | Constant parity bit |
| trig_sel | input | 2 | Receive-ready threshold code |
| pop | input | 1 | Removes one word from the queue |
| pop_data | output | 12 | Word returned by the last pop: {break, framing, overrun, parity, data[7:0]} |
| occupancy | output | 16 | Number of stored words |
| rx_ready | output | 1 | Count has reached the selected threshold |

## Verification
The bench fills the queue to exactly 512 words and sends one more character; a queue that wrapped its write pointer would overwrite the oldest word and pop the wrong first value, and one that forgot the dropped character would leave bit 9 clear on the next word. It probes the thresholds one word below and at 256 and 448, so an off-by-one comparison shows up as receive-ready rising a word early or late. A held-low line must produce exactly one break word followed by a clean character; a receiver without the wait for a high line would store a stream of spurious break or framing words. Stick parity with both polarities and a low second stop bit catch a parity rule or stop check that follows the wrong setting.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ENTRY_W = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2,
        S_HOLD
    } rx_state_t;

    // Packed MSB first: break at 11, framing 10, overrun 9, parity 8.
    typedef struct packed {
        logic       brk;
        logic       frame;
        logic       ovr;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rxf_baud_tick.sv
module rxf_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rxf_deser.sv
module rxf_deser
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic      enable,
    input  logic [1:0] data_len_sel,
    input  logic      two_stop,
    input  logic      par_enable,
    input  logic      par_even,
    input  logic      par_stick,
    output logic      push,
    output rx_entry_t entry
);

    localparam logic [3:0] HALF_LAST = 4'd7;
    localparam logic [3:0] FULL_LAST = 4'd15;

    rx_state_t  state_q, state_d;
    logic [3:0] tcnt_q;
    logic [2:0] bitcnt_q;
    logic [7:0] shreg_q;
    logic       par_acc_q, all_low_q, par_bad_q;
    logic       mid, exp_par;
    logic [2:0] last_bit;
    logic [7:0] aligned;

    always_comb begin
        mid      = tick && (tcnt_q == ((state_q == S_START) ? HALF_LAST : FULL_LAST));
        last_bit = {1'b0, data_len_sel} + 3'd4;
        exp_par  = par_stick ? ~par_even : (par_acc_q ^ ~par_even);
        aligned  = shreg_q >> (2'd3 - data_len_sel);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (enable && tick && !rx) state_d = S_START;
            S_START:  if (mid) state_d = rx ? S_IDLE : S_DATA;
            S_DATA:   if (mid && bitcnt_q == last_bit)
                          state_d = par_enable ? S_PARITY : S_STOP1;
            S_PARITY: if (mid) state_d = S_STOP1;
            S_STOP1:  if (mid) state_d = !rx ? S_HOLD : (two_stop ? S_STOP2 : S_IDLE);
            S_STOP2:  if (mid) state_d = rx ? S_IDLE : S_HOLD;
            S_HOLD:   if (rx) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q    <= '0;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            all_low_q <= 1'b0;
            par_bad_q <= 1'b0;
            push      <= 1'b0;
            entry     <= '0;
        end else begin
            push <= 1'b0;
            if (state_d != state_q) tcnt_q <= '0;
            else if (tick)          tcnt_q <= tcnt_q + 1'b1;

            unique case (state_q)
                S_IDLE: begin
                    if (state_d == S_START) begin
                        shreg_q   <= '0;
                        bitcnt_q  <= '0;
                        par_acc_q <= 1'b0;
                        all_low_q <= 1'b1;
                        par_bad_q <= 1'b0;
                    end
                end
                S_DATA: begin
                    if (mid) begin
                        shreg_q   <= {rx, shreg_q[7:1]};
                        par_acc_q <= par_acc_q ^ rx;
                        all_low_q <= all_low_q & ~rx;
                        bitcnt_q  <= bitcnt_q + 1'b1;
                    end
                end
                S_PARITY: begin
                    if (mid) begin
                        all_low_q <= all_low_q & ~rx;
                        par_bad_q <= (rx != exp_par);
                    end
                end
                S_STOP1: begin
                    if (mid) begin
                        if (!rx && all_low_q) begin
                            push  <= enable;
                            entry <= '{brk: 1'b1, frame: 1'b0, ovr: 1'b0,
                                       par: 1'b0, data: 8'h00};
                        end else if (!rx || !two_stop) begin
                            push  <= enable;
                            entry <= '{brk: 1'b0, frame: ~rx, ovr: 1'b0,
                                       par: par_bad_q, data: aligned};
                        end
                    end
                end
                S_STOP2: begin
                    if (mid) begin
                        push  <= enable;
                        entry <= '{brk: 1'b0, frame: ~rx, ovr: 1'b0,
                                   par: par_bad_q, data: aligned};
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  rx_entry_t          wentry,
    input  logic               pop,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [CNT_W-1:0]   count
);

    rx_entry_t         mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic              ovr_pend_q;
    logic              full, accept, take;
    rx_entry_t         wr_e;

    always_comb begin
        full   = (count == CNT_W'(DEPTH));
        accept = push && !full && !flush;
        take   = pop && (count != '0) && !flush;
        wr_e   = wentry;
        wr_e.ovr = wentry.ovr | ovr_pend_q;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wptr_q] <= wr_e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q     <= '0;
            rptr_q     <= '0;
            count      <= '0;
            ovr_pend_q <= 1'b0;
            rd_data    <= '0;
        end else if (flush) begin
            wptr_q     <= '0;
            rptr_q     <= '0;
            count      <= '0;
            ovr_pend_q <= 1'b0;
            if (pop) rd_data <= '0;
        end else begin
            if (accept) begin
                wptr_q     <= wptr_q + 1'b1;
                ovr_pend_q <= 1'b0;
            end else if (push) begin
                ovr_pend_q <= 1'b1;
            end
            if (take) begin
                rd_data <= mem[rptr_q];
                rptr_q  <= rptr_q + 1'b1;
            end else if (pop) begin
                rd_data <= '0;
            end
            count <= count + CNT_W'(accept) - CNT_W'(take);
        end
    end

endmodule

// File: rtl/serial_rx_tagfifo.sv
module serial_rx_tagfifo
    import rxf_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int DIV_W     = 16,
    parameter int OCC_W     = 16,
    parameter int TRIG_MID  = 256,
    parameter int TRIG_HIGH = 448,
    localparam int CNT_W    = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_line,
    input  logic               rx_enable,
    input  logic               flush_rx,
    input  logic [DIV_W-1:0]   baud_div_m1,
    input  logic [1:0]         data_len_sel,
    input  logic               two_stop,
    input  logic               par_enable,
    input  logic               par_even,
    input  logic               par_stick,
    input  logic [1:0]         trig_sel,
    input  logic               pop,
    output logic [ENTRY_W-1:0] pop_data,
    output logic [OCC_W-1:0]   occupancy,
    output logic               rx_ready
);

    logic             rx_s1, rx_s2;
    logic             tick;
    logic             deser_push;
    rx_entry_t        deser_entry;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_s1 <= 1'b1;
            rx_s2 <= 1'b1;
        end else begin
            rx_s1 <= rx_line;
            rx_s2 <= rx_s1;
        end
    end

    rxf_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_m1 (baud_div_m1),
        .tick   (tick)
    );

    rxf_deser u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .rx           (rx_s2),
        .enable       (rx_enable),
        .data_len_sel (data_len_sel),
        .two_stop     (two_stop),
        .par_enable   (par_enable),
        .par_even     (par_even),
        .par_stick    (par_stick),
        .push         (deser_push),
        .entry        (deser_entry)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_rx),
        .push    (deser_push),
        .wentry  (deser_entry),
        .pop     (pop),
        .rd_data (pop_data),
        .count   (count)
    );

    assign occupancy = OCC_W'(count);

    always_comb begin
        unique case (trig_sel)
            2'd0:    rx_ready = 1'b0;
            2'd1:    rx_ready = (count != '0);
            2'd2:    rx_ready = (count >= CNT_W'(TRIG_MID));
            default: rx_ready = (count >= CNT_W'(TRIG_HIGH));
        endcase
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_rx,
    input logic        pop,
    input logic        rx_enable,
    input logic        push,
    input logic [15:0] occupancy,
    input logic [11:0] pop_data
);

    a_r12_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= 16'(DEPTH));

    a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_rx |=> (occupancy == $past(occupancy)) ||
                      (occupancy == $past(occupancy) + 16'd1) ||
                      (occupancy + 16'd1 == $past(occupancy)));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rx |=> occupancy == 16'd0);

    a_r8_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && occupancy == 16'd0) |=> pop_data == 12'd0);

    a_r11_disabled_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !push);

    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == 16'(DEPTH) && !pop && !flush_rx) |=> occupancy == 16'(DEPTH));

endmodule

bind serial_rx_tagfifo rxf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_rx  (flush_rx),
    .pop       (pop),
    .rx_enable (rx_enable),
    .push      (deser_push),
    .occupancy (occupancy),
    .pop_data  (pop_data)
);

// File: tb/serial_rx_tagfifo_test.sv
module serial_rx_tagfifo_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        rx_enable = 1'b1;
    logic        flush_rx = 1'b0;
    logic [15:0] baud_div_m1 = 16'd0;
    logic [1:0]  data_len_sel = 2'd3;
    logic        two_stop = 1'b0;
    logic        par_enable = 1'b0;
    logic        par_even = 1'b0;
    logic        par_stick = 1'b0;
    logic [1:0]  trig_sel = 2'd1;
    logic        pop = 1'b0;
    logic [11:0] pop_data;
    logic [15:0] occupancy;
    logic        rx_ready;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int bit_clks = 16;

    serial_rx_tagfifo uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_enable(rx_enable),
        .flush_rx(flush_rx), .baud_div_m1(baud_div_m1), .data_len_sel(data_len_sel),
        .two_stop(two_stop), .par_enable(par_enable), .par_even(par_even),
        .par_stick(par_stick), .trig_sel(trig_sel), .pop(pop),
        .pop_data(pop_data), .occupancy(occupancy), .rx_ready(rx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk) rx_line = b;
        repeat (bit_clks - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit use_par,
                              input bit pbit, input bit s1, input bit use_s2, input bit s2);
        drive_bit(1'b0);
        for (int k = 0; k < nb; k++) drive_bit(d[k]);
        if (use_par) drive_bit(pbit);
        drive_bit(s1);
        if (use_s2) drive_bit(s2);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic send_plain(input logic [7:0] d, input int nb);
        send_frame(d, nb, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic do_pop(output logic [11:0] v);
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
        v = pop_data;
    endtask

    task automatic set_rate(input logic [15:0] d);
        baud_div_m1 = d;
        bit_clks = 16 * (int'(d) + 1);
    endtask

    task automatic t_reset();
        check("R1 occupancy after reset", 32'(occupancy), 32'd0);
        check("R1 pop_data after reset", 32'(pop_data), 32'd0);
        check("R1 rx_ready after reset", 32'(rx_ready), 32'd0);
    endtask

    task automatic t_basic();
        logic [11:0] v;
        send_plain(8'hA5, 8);
        send_plain(8'h3C, 8);
        check("R8 occupancy after two frames", 32'(occupancy), 32'd2);
        check("R9 ready at code 1 with data", 32'(rx_ready), 32'd1);
        trig_sel = 2'd0;
        @(negedge clk);
        check("R9 ready at code 0", 32'(rx_ready), 32'd0);
        trig_sel = 2'd1;
        do_pop(v);
        check("R2 first word 8 bits", 32'(v), 32'h0A5);
        check("R8 count after one pop", 32'(occupancy), 32'd1);
        do_pop(v);
        check("R8 second word order", 32'(v), 32'h03C);
        check("R9 ready low when empty", 32'(rx_ready), 32'd0);
    endtask

    task automatic t_lengths();
        logic [11:0] v;
        data_len_sel = 2'd0; send_plain(8'h15, 5); do_pop(v);
        check("R2 five data bits", 32'(v), 32'h015);
        data_len_sel = 2'd1; send_plain(8'h2A, 6); do_pop(v);
        check("R2 six data bits", 32'(v), 32'h02A);
        data_len_sel = 2'd2; send_plain(8'h55, 7); do_pop(v);
        check("R2 seven data bits", 32'(v), 32'h055);
        data_len_sel = 2'd3;
    endtask

    task automatic t_rate();
        logic [11:0] v;
        set_rate(16'd2);
        send_plain(8'h96, 8); do_pop(v);
        check("R3 divisor field 2 (48 cycles per bit)", 32'(v), 32'h096);
        set_rate(16'd0);
    endtask

    task automatic t_parity();
        logic [11:0] v;
        par_enable = 1'b1;
        par_even = 1'b1; par_stick = 1'b0;
        send_frame(8'h5A, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1); do_pop(v);
        check("R4 even parity good", 32'(v), 32'h05A);
        send_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); do_pop(v);
        check("R4 even parity bad sets bit 8", 32'(v), 32'h15A);
        par_even = 1'b0;
        send_frame(8'h07, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1); do_pop(v);
        check("R4 odd parity good", 32'(v), 32'h007);
        par_stick = 1'b1;
        send_frame(8'h81, 8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); do_pop(v);
        check("R4 stick mark parity good", 32'(v), 32'h081);
        par_even = 1'b1;
        send_frame(8'h81, 8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); do_pop(v);
        check("R4 stick space parity bad", 32'(v), 32'h181);
        par_enable = 1'b0; par_stick = 1'b0; par_even = 1'b0;
    endtask

    task automatic t_stop();
        logic [11:0] v;
        send_frame(8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); do_pop(v);
        check("R5 low stop bit sets bit 10", 32'(v), 32'h442);
        two_stop = 1'b1;
        send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1); do_pop(v);
        check("R5 two good stop bits", 32'(v), 32'h06E);
        send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); do_pop(v);
        check("R5 low second stop bit", 32'(v), 32'h46E);
        two_stop = 1'b0;
        check("R5 single word per bad frame", 32'(occupancy), 32'd0);
    endtask

    task automatic t_break();
        logic [11:0] v;
        @(negedge clk) rx_line = 1'b0;
        repeat (14 * bit_clks) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * bit_clks) @(negedge clk);
        check("R6 one word for a break", 32'(occupancy), 32'd1);
        do_pop(v);
        check("R6 break word", 32'(v), 32'h800);
        send_plain(8'h33, 8); do_pop(v);
        check("R6 clean character after break", 32'(v), 32'h033);
    endtask

    task automatic t_empty_pop();
        logic [11:0] v;
        do_pop(v);
        check("R8 pop on empty returns 0", 32'(v), 32'd0);
        check("R8 pop on empty keeps count", 32'(occupancy), 32'd0);
    endtask

    task automatic t_enable();
        rx_enable = 1'b0;
        send_plain(8'hC3, 8);
        check("R11 disabled frame not stored", 32'(occupancy), 32'd0);
        rx_enable = 1'b1;
    endtask

    task automatic t_flush();
        logic [11:0] v;
        send_plain(8'h11, 8);
        send_plain(8'h22, 8);
        @(negedge clk) flush_rx = 1'b1;
        @(negedge clk);
        check("R10 count zero under flush", 32'(occupancy), 32'd0);
        send_plain(8'h77, 8);
        check("R10 frame during flush dropped", 32'(occupancy), 32'd0);
        flush_rx = 1'b0;
        send_plain(8'h12, 8); do_pop(v);
        check("R10 first word after flush", 32'(v), 32'h012);
    endtask

    task automatic t_fill();
        logic [11:0] v;
        logic [11:0] last;
        int bad;
        data_len_sel = 2'd0;
        trig_sel = 2'd2;
        for (int i = 0; i < 512; i++) begin
            send_plain(8'(i % 32), 5);
            if (i == 254) check("R9 code 2 low at 255 words", 32'(rx_ready), 32'd0);
            if (i == 255) begin
                check("R9 code 2 high at 256 words", 32'(rx_ready), 32'd1);
                trig_sel = 2'd3;
            end
            if (i == 446) check("R9 code 3 low at 447 words", 32'(rx_ready), 32'd0);
            if (i == 447) check("R9 code 3 high at 448 words", 32'(rx_ready), 32'd1);
        end
        check("R12 occupancy full", 32'(occupancy), 32'd512);
        send_plain(8'h1F, 5);
        check("R7 full queue drops character", 32'(occupancy), 32'd512);
        do_pop(v);
        check("R7 oldest word kept", 32'(v), 32'h000);
        send_plain(8'h0A, 5);
        check("R7 count after refill", 32'(occupancy), 32'd512);
        bad = 0;
        for (int i = 1; i < 512; i++) begin
            do_pop(v);
            if (v !== 12'(i % 32)) bad++;
        end
        check("R2 five-bit words in order", 32'(bad), 32'd0);
        do_pop(last);
        check("R7 overrun mark on next word", 32'(last), 32'h20A);
        check("R8 empty after draining", 32'(occupancy), 32'd0);
        data_len_sel = 2'd3;
        trig_sel = 2'd1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_rate();
        t_parity();
        t_stop();
        t_break();
        t_empty_pop();
        t_enable();
        t_flush();
        t_fill();
        summary();
    end

endmodule